// File: doc/BRIEF.md
# Recirculating Sequencer Memory with Blank Skip

This block stores a short melodic sequence as a chain of note words in a 256-stage shift memory and plays it back by feeding the memory's tail word into its head. Each word carries a 5-bit note code in bits [4:0] and a trigger flag in bit [5]. The all-ones word (6'h3F) marks an empty location. Ordinary note data never takes that value.

Three control inputs select the behaviour. A record strobe wipes the memory to empty words at the fast rate. A keyboard strobe then opens the input so that live words enter at the slow rate. Holding the play pad turns the chain into a loop. During replay, the tail word decides the shift rate. An empty word at the tail selects the fast rate, so unused storage is passed in a burst. A data word selects the slow rate, so the tune plays at its own tempo. The tail word is also the block's output. Every empty word at the tail zeroes the step counter, so the counter gives each played word's position in the sequence.

Holding the play pad pauses replay on the first empty word. Releasing it restarts from the sequence start once a short release filter has timed out. The rates arrive as one-cycle tick enables from elsewhere in the chip.

Top module: `recirc_seq_mem`

## Requirements
- R1: After reset, out_word is 6'h3F, step_cnt is 0, playing is 0, and the block is in the wipe state with every stage empty.
- R2: A cycle with rec_req high enters the wipe state from any state, taking priority over the other controls. In the wipe state, each fast_tick shifts the empty word 6'h3F into the memory, live_word is ignored, and step_cnt is held at 0.
- R3: A key_req pulse in the wipe state enters the record state. In the record state, each slow_tick shifts live_word into the head, fast_tick has no effect, and step_cnt counts the shifted words modulo 256.
- R4: The memory has 256 stages. After N > 256 recorded words, out_word equals the word entered in position N-256 (counting from 0), and older words are lost.
- R5: play_hold has no effect in the wipe state: a later key_req still enters the record state normally.
- R6: play_hold high in the record state enters the play state in the paused condition.
- R7: In the play state, with no pause, the tail word is written back to the head. An empty tail advances only on fast_tick, and a data tail advances only on slow_tick, so exactly one of the two tick inputs drives each shift.
- R8: In the play state, step_cnt is 0 while the tail is empty and rises by one on each shift of a data word. playing is high only in the play state, with no pause, while the tail holds a data word.
- R9: While paused (play_hold high, or the release filter still running), a data tail advances on fast_tick and an empty tail halts, so playback stops on the first empty word.
- R10: The pause ends only after play_hold has been low for REL_HOLD consecutive cycles (default 16). A shorter release restarts the filter.
- R11: When no empty word is stored, a paused memory keeps recirculating at the fast rate and never halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable at the tempo rate |
| fast_tick | input | 1 | One-cycle enable at the skip rate |
| rec_req | input | 1 | Record pad strobe: wipe the memory |
| key_req | input | 1 | Keyboard strobe: start accepting live words |
| play_hold | input | 1 | Play pad level: loop the memory, pause while held |
| live_word | input | 6 | Live note word: trigger flag in bit 5, note in bits 4:0 |
| out_word | output | 6 | Word at the memory tail |
| step_cnt | output | 8 | Position of the tail word within the sequence |
| playing | output | 1 | High while a data word is being replayed |

## Verification
The two tick inputs often land in the same cycle, and the rate selector must then let only one of them shift the chain. The bench keeps fast_tick high on every cycle and pulses slow_tick on top of it. Every recorded and replayed word must then appear once per slow pulse, with step_cnt rising by one and never skipping. A second coincidence is a pause request arriving while the tail holds data. This is judged by the chain racing to the first empty word and halting there with step_cnt at 0, then restarting at the first recorded word only after the release filter has expired.

// File: rtl/recirc_seq_pkg.sv
// Shared definitions for the recirculating sequencer memory.
// Assumes: a three-state control flow (wipe, record, play).
package recirc_seq_pkg;

    typedef enum logic [1:0] {
        MODE_WIPE   = 2'd0,
        MODE_RECORD = 2'd1,
        MODE_PLAY   = 2'd2
    } seq_mode_e;

endpackage

// File: rtl/seq_shift_store.sv
// Word-wide shift chain: head takes din, the last stage is the tail.
// Assumes: the reset value of every stage is the all-ones empty word.
module seq_shift_store #(
    parameter int DEPTH  = 256,
    parameter int WORD_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] tail
);

    logic [DEPTH-1:0][WORD_W-1:0] chain;

    // Advance every stage by one place on each enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else if (shift_en) begin
            chain <= {chain[DEPTH-2:0], din};
        end
    end

    // Tail is the oldest stored word.
    always_comb tail = chain[DEPTH-1];

    // R7
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(tail));

endmodule

// File: rtl/seq_mode_ctrl.sv
// Control state machine, pause/release filter and shift-rate selection.
// Assumes: rec_req outranks key_req and play_hold; the tick inputs last one cycle.
module seq_mode_ctrl
    import recirc_seq_pkg::*;
#(
    parameter int WORD_W   = 6,
    parameter int REL_HOLD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              rec_req,
    input  logic              key_req,
    input  logic              play_hold,
    input  logic [WORD_W-1:0] live_word,
    input  logic [WORD_W-1:0] tail,
    output seq_mode_e         mode,
    output logic              paused,
    output logic              tail_empty,
    output logic              shift_en,
    output logic [WORD_W-1:0] din,
    output logic              step_clr,
    output logic              step_inc
);

    localparam int RC_W = $clog2(REL_HOLD + 1);
    localparam logic [RC_W-1:0] REL_LAST = RC_W'(REL_HOLD - 1);
    localparam logic [WORD_W-1:0] EMPTY_WORD = '1;

    logic [RC_W-1:0] rel_cnt;
    logic            hold_eff;

    // Empty-location detector on the tail word.
    always_comb tail_empty = (tail == EMPTY_WORD);

    // Pause is live while the pad is down or the release filter is running.
    always_comb hold_eff = paused | play_hold;

    // Choose the shift enable and head word for the current state.
    always_comb begin
        shift_en = 1'b0;
        din      = EMPTY_WORD;
        unique case (mode)
            MODE_WIPE: begin
                shift_en = fast_tick;
                din      = EMPTY_WORD;
            end
            MODE_RECORD: begin
                shift_en = slow_tick;
                din      = live_word;
            end
            MODE_PLAY: begin
                din = tail;
                if (hold_eff) shift_en = tail_empty ? 1'b0 : fast_tick;
                else          shift_en = tail_empty ? fast_tick : slow_tick;
            end
            default: begin
                shift_en = 1'b0;
                din      = EMPTY_WORD;
            end
        endcase
    end

    // Step counter controls: zero on wipe or empty tail, count data shifts.
    always_comb begin
        step_clr = (mode == MODE_WIPE) || ((mode == MODE_PLAY) && tail_empty);
        step_inc = shift_en && ((mode == MODE_RECORD) ||
                                ((mode == MODE_PLAY) && !tail_empty));
    end

    // State transitions: wipe on rec_req, record on key_req, play on play_hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_WIPE;
        end else if (rec_req) begin
            mode <= MODE_WIPE;
        end else begin
            unique case (mode)
                MODE_WIPE:   if (key_req)   mode <= MODE_RECORD;
                MODE_RECORD: if (play_hold) mode <= MODE_PLAY;
                MODE_PLAY:   mode <= MODE_PLAY;
                default:     mode <= MODE_WIPE;
            endcase
        end
    end

    // Pause flag with a release filter of REL_HOLD quiet cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paused  <= 1'b1;
            rel_cnt <= '0;
        end else if (mode != MODE_PLAY || play_hold) begin
            paused  <= 1'b1;
            rel_cnt <= '0;
        end else if (paused) begin
            if (rel_cnt == REL_LAST) begin
                paused  <= 1'b0;
                rel_cnt <= '0;
            end else begin
                rel_cnt <= rel_cnt + 1'b1;
            end
        end
    end

    // R10
    release_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PLAY && play_hold && !rec_req) |=> paused);

    // R7
    one_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> (fast_tick || slow_tick));

endmodule

// File: rtl/seq_step_counter.sv
// Sequence position counter, wrapping at the memory depth.
// Assumes: clear outranks increment.
module seq_step_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    // Count data shifts; return to zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/recirc_seq_mem.sv
// Recirculating sequencer memory with automatic skipping of empty words.
// Assumes: the all-ones word never appears in live note data.
module recirc_seq_mem
    import recirc_seq_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter int NOTE_W   = 5,
    parameter int REL_HOLD = 16,
    localparam int WORD_W  = NOTE_W + 1,
    localparam int CNT_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              rec_req,
    input  logic              key_req,
    input  logic              play_hold,
    input  logic [WORD_W-1:0] live_word,
    output logic [WORD_W-1:0] out_word,
    output logic [CNT_W-1:0]  step_cnt,
    output logic              playing
);

    seq_mode_e         mode;
    logic              paused;
    logic              tail_empty;
    logic              shift_en;
    logic [WORD_W-1:0] din;
    logic              step_clr;
    logic              step_inc;

    seq_mode_ctrl #(.WORD_W(WORD_W), .REL_HOLD(REL_HOLD)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .rec_req(rec_req), .key_req(key_req), .play_hold(play_hold),
        .live_word(live_word), .tail(out_word), .mode(mode), .paused(paused),
        .tail_empty(tail_empty), .shift_en(shift_en), .din(din),
        .step_clr(step_clr), .step_inc(step_inc)
    );

    seq_shift_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(din), .tail(out_word)
    );

    seq_step_counter #(.CNT_W(CNT_W)) u_step (
        .clk(clk), .rst_n(rst_n), .clr(step_clr), .inc(step_inc), .cnt(step_cnt)
    );

    // Replay indicator: unpaused play with a data word at the tail.
    always_comb playing = (mode == MODE_PLAY) && !paused && !tail_empty;

    // R8
    playing_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        playing |-> (out_word != '1));

    // R8
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PLAY && out_word == '1) |=> (step_cnt == '0));

    // R2
    wipe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WIPE) |=> (step_cnt == '0));

    // R9
    halt_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PLAY && play_hold && out_word == '1) |=> (out_word == '1));

    // R7
    slow_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PLAY && !paused && !play_hold && !rec_req &&
         out_word != '1 && !slow_tick) |=> $stable(out_word));

endmodule

// File: tb/tb_recirc_seq_mem.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_recirc_seq_mem;

    localparam int REL_HOLD = 16;
    localparam logic [5:0] EMPTY = 6'h3F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       fast_tick = 1'b0;
    logic       rec_req = 1'b0;
    logic       key_req = 1'b0;
    logic       play_hold = 1'b0;
    logic [5:0] live_word = 6'h00;
    logic [5:0] out_word;
    logic [7:0] step_cnt;
    logic       playing;

    int n_run = 0;
    int n_fail = 0;
    logic [5:0] seq [5] = '{6'h01, 6'h22, 6'h13, 6'h27, 6'h0A};

    recirc_seq_mem #(.REL_HOLD(REL_HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .rec_req(rec_req), .key_req(key_req), .play_hold(play_hold),
        .live_word(live_word), .out_word(out_word), .step_cnt(step_cnt),
        .playing(playing)
    );

    always #2 clk = ~clk;

    task automatic check_eq(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_slow();
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_rec();
        rec_req = 1'b1;
        @(negedge clk);
        rec_req = 1'b0;
    endtask

    task automatic pulse_key();
        key_req = 1'b1;
        @(negedge clk);
        key_req = 1'b0;
    endtask

    task automatic wait_data(output int n);
        n = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            n++;
            if (out_word != EMPTY) break;
        end
    endtask

    task automatic wipe_all();
        pulse_rec();
        wait_cyc(300);
    endtask

    task automatic t_reset();
        check_eq("R1 out_word", out_word, EMPTY);
        check_eq("R1 step_cnt", step_cnt, 0);
        check_eq("R1 playing", playing, 0);
    endtask

    task automatic t_wipe();
        live_word = 6'h05;
        wipe_all();
        check_eq("R2 wipe out_word", out_word, EMPTY);
        check_eq("R2 wipe step_cnt", step_cnt, 0);
    endtask

    task automatic t_play_in_wipe();
        play_hold = 1'b1;
        wait_cyc(3);
        play_hold = 1'b0;
        wait_cyc(2);
        pulse_key();
        live_word = 6'h05;
        pulse_slow();
        check_eq("R5 record after play in wipe", step_cnt, 1);
        check_eq("R5 playing", playing, 0);
    endtask

    task automatic t_record();
        wipe_all();
        pulse_key();
        for (int i = 0; i < 5; i++) begin
            live_word = seq[i];
            pulse_slow();
        end
        check_eq("R3 record count", step_cnt, 5);
        check_eq("R3 fast ignored, tail", out_word, EMPTY);
    endtask

    task automatic t_play();
        int n;
        play_hold = 1'b1;
        wait_cyc(2);
        for (int i = 0; i < 4; i++) pulse_slow();
        check_eq("R6 paused tail", out_word, EMPTY);
        check_eq("R6 paused step", step_cnt, 0);
        check_eq("R6 paused playing", playing, 0);
        play_hold = 1'b0;
        wait_data(n);
        check_eq("R7 first word", out_word, seq[0]);
        check_eq("R8 first step", step_cnt, 0);
        check_eq("R8 playing", playing, 1);
        for (int k = 1; k < 5; k++) begin
            pulse_slow();
            check_eq("R7 replay word", out_word, seq[k]);
            check_eq("R8 replay step", step_cnt, k);
        end
        pulse_slow();
        check_eq("R8 end empty", out_word, EMPTY);
        check_eq("R8 end step", step_cnt, 0);
    endtask

    task automatic t_pause();
        int n;
        wait_data(n);
        check_eq("R7 loop restart", out_word, seq[0]);
        pulse_slow();
        pulse_slow();
        check_eq("R7 third word", out_word, seq[2]);
        play_hold = 1'b1;
        wait_cyc(8);
        check_eq("R9 halt empty", out_word, EMPTY);
        check_eq("R9 halt step", step_cnt, 0);
        check_eq("R9 halt playing", playing, 0);
        for (int i = 0; i < 5; i++) pulse_slow();
        check_eq("R9 still halted", out_word, EMPTY);
        play_hold = 1'b0;
        wait_data(n);
        check_eq("R9 resume word", out_word, seq[0]);
        check_eq("R9 resume step", step_cnt, 0);
    endtask

    task automatic t_filter();
        int n;
        wipe_all();
        pulse_key();
        slow_tick = 1'b1;
        for (int i = 0; i < 255; i++) begin
            live_word = {i[0], 5'(i % 30)};
            @(negedge clk);
        end
        slow_tick = 1'b0;
        play_hold = 1'b1;
        wait_cyc(20);
        check_eq("R10 halted on single gap", out_word, EMPTY);
        play_hold = 1'b0;
        wait_cyc(6);
        play_hold = 1'b1;
        wait_cyc(2);
        play_hold = 1'b0;
        wait_data(n);
        n_run++;
        if (n < REL_HOLD || n > REL_HOLD + 3) begin
            n_fail++;
            $display("FAIL R10 release delay actual=%0d expected=%0d..%0d",
                     n, REL_HOLD, REL_HOLD + 3);
        end
        check_eq("R10 restart word", out_word, 6'h00);
    endtask

    task automatic t_overfill();
        int empties;
        int moves;
        logic [5:0] prev;
        wipe_all();
        pulse_key();
        slow_tick = 1'b1;
        for (int i = 0; i < 260; i++) begin
            live_word = {1'b0, 5'(i % 29)};
            @(negedge clk);
        end
        slow_tick = 1'b0;
        check_eq("R4 oldest kept", out_word, 6'h04);
        play_hold = 1'b1;
        @(negedge clk);
        empties = 0;
        moves = 0;
        prev = out_word;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (out_word == EMPTY) empties++;
            if (out_word != prev) moves++;
            prev = out_word;
        end
        check_eq("R11 no gap found", empties, 0);
        n_run++;
        if (moves < 590) begin
            n_fail++;
            $display("FAIL R11 fast race moves actual=%0d expected>=590", moves);
        end
        play_hold = 1'b0;
        wait_cyc(REL_HOLD + 4);
    endtask

    task automatic t_wipe_from_play();
        wipe_all();
        check_eq("R2 wipe from play out", out_word, EMPTY);
        check_eq("R2 wipe from play step", step_cnt, 0);
        check_eq("R2 wipe from play playing", playing, 0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        fast_tick = 1'b1;
        t_wipe();
        t_play_in_wipe();
        t_record();
        t_play();
        t_pause();
        t_filter();
        t_overfill();
        t_wipe_from_play();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule